// File: doc/BRIEF.md
# I2C master register controller

This block is the processor-facing front end of an I2C master. Software reads and writes five byte-wide registers over a simple request/acknowledge register bus: a control register, a status register, a data register, an own-address register and a clock-divider register. The block turns those accesses into byte-level commands for a separate bus engine. The commands are start with an address byte, send a byte, receive a byte, and stop. The engine answers each command with an acknowledge result.

The first data-register write after the block has become idle is the address phase. Bits 7:1 of that byte are the target address and bit 0 is the direction. Later writes send data bytes. In master mode, each read of the data register fetches the next byte from the target. The block records whether a target address is open and keeps the busy, received-NACK, interrupt and arbitration-lost flags. It drives one level interrupt output. Clearing the enable bit while the block is enabled performs a soft reset that keeps the own-address register.

Top module: `i2cm_host_ctl`

## Requirements
- R1: After reset, every register reads 0x00, `irq` is low and `txn_valid` is low.
- R2: Register offsets are control 0, status 1, data 2, own address 3 and divider 4. Only `reg_wdata[7:0]` is used. The own-address register keeps bits 7:1 (mask 0xFE), the divider keeps bits 5:0 (mask 0x3F) and the control register keeps bits 7:2 (mask 0xFC). Offsets 5 to 7 read 0x00, and writes to them change nothing.
- R3: The control bits are: 7 enable, 6 interrupt enable, 5 master, 4 transmit direction, 3 no-acknowledge, 2 repeated start. A control write with bit 7 clear while enable is set is a soft reset. It returns every register and flag to its reset value except the own-address register, and it issues a stop if an address was open.
- R4: Any other control write sets the busy status bit (status bit 5) when it sets master, and clears busy when it clears master. Clearing master while an address is open issues a stop and closes the address.
- R5: A normal control write with master and repeated start both set while an address is open issues a stop and closes the address. The control register then reads with bit 2 clear.
- R6: The status bits are: 5 busy, 4 arbitration lost, 1 interrupt flag, 0 received NACK. A status write clears the interrupt flag or the arbitration-lost flag only where the written bit is 0. A 1 leaves that flag unchanged. `irq` equals the interrupt flag.
- R7: An interrupt event sets the interrupt flag only when control bits 7 and 6 are both 1.
- R8: A data write is ignored while enable is clear. In master mode with no address open, it issues a start carrying the byte (command 0). A NACK sets status bit 0. An ACK opens the address, clears status bit 0 and raises an interrupt event.
- R9: In master mode with an address open, a data write issues a send of the byte (command 1). An ACK clears status bit 0 and raises an interrupt event. A NACK sets status bit 0, closes the address and issues a stop (command 3).
- R10: In master mode, a data read with an address open and control bit 4 clear issues a receive (command 2). The read returns the received byte and raises an interrupt event. Otherwise no command is issued, and both the read and the data register hold 0xFF.
- R11: With master clear, data accesses issue no command. A data read returns the last value held in the data register.
- R12: A command that completes with `txn_lost` high sets the arbitration-lost flag (status bit 4).
- R13: `txn_valid` stays high, with the command and byte stable, until `txn_done`. A register access that issues a command is acknowledged only after the last command it issued completes. `reg_ack` is a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_req | input | 1 | Register access request, held until `reg_ack` |
| reg_we | input | 1 | 1 for write, 0 for read |
| reg_addr | input | ADDR_W | Register offset |
| reg_wdata | input | BUS_W | Write data, low byte used |
| reg_ack | output | 1 | Access complete pulse |
| reg_rdata | output | BUS_W | Read data, valid with `reg_ack` |
| irq | output | 1 | Interrupt level |
| txn_valid | output | 1 | Command to bus engine pending |
| txn_cmd | output | 2 | 0 start, 1 send, 2 receive, 3 stop |
| txn_wbyte | output | 8 | Address or data byte for start/send |
| txn_done | input | 1 | Bus engine completion pulse |
| txn_nack | input | 1 | Target did not acknowledge |
| txn_lost | input | 1 | Arbitration lost during the command |
| txn_rbyte | input | 8 | Byte received by a receive command |

## Verification
The embedded assertions check several rules on every cycle. They cover the command handshake (valid held, command and byte stable until done), the single-cycle acknowledge, acknowledge from a bus access only after done, interrupt-flag rises only while both enables are set, and flag clears only through a zero write or a soft reset. They also check that busy rises only from a master control write and that a start is never issued while disabled or in slave mode. The sequencing itself can only be shown by the bench's scenarios. That covers which commands an access produces and in what order (the chained stop after a NACKed send, the stop on repeated start or on leaving master mode), the 0xFF substitution on a read that cannot receive, and the soft reset that keeps the own address.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    CMD_START = 2'd0,
    CMD_SEND  = 2'd1,
    CMD_RECV  = 2'd2,
    CMD_STOP  = 2'd3
  } i2cm_cmd_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUS  = 1'b1
  } i2cm_state_e;

  // register offsets
  localparam int OFS_CTRL = 0;
  localparam int OFS_STAT = 1;
  localparam int OFS_DATA = 2;
  localparam int OFS_OWN  = 3;
  localparam int OFS_DIV  = 4;

  // control bits
  localparam int CB_EN    = 7;
  localparam int CB_IEN   = 6;
  localparam int CB_MST   = 5;
  localparam int CB_TX    = 4;
  localparam int CB_NOACK = 3;
  localparam int CB_RSTA  = 2;

  // status bits
  localparam int SB_BUSY = 5;
  localparam int SB_ARB  = 4;
  localparam int SB_IRQ  = 1;
  localparam int SB_NACK = 0;

  localparam logic [BYTE_W-1:0] MASK_CTRL = 8'hFC;
  localparam logic [BYTE_W-1:0] MASK_OWN  = 8'hFE;
  localparam logic [BYTE_W-1:0] MASK_DIV  = 8'h3F;
  localparam logic [BYTE_W-1:0] RX_NONE   = 8'hFF;

endpackage

// File: rtl/i2cm_txn_port.sv
module i2cm_txn_port
  import i2cm_pkg::*;
#(
  parameter int W = BYTE_W
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        issue,
  input  i2cm_cmd_e   issue_cmd,
  input  logic [W-1:0] issue_byte,
  input  logic        done,
  output logic        valid,
  output i2cm_cmd_e   cmd,
  output logic [W-1:0] wbyte
);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      cmd   <= CMD_STOP;
      wbyte <= '0;
    end else if (issue) begin
      valid <= 1'b1;
      cmd   <= issue_cmd;
      wbyte <= issue_byte;
    end else if (done) begin
      valid <= 1'b0;
    end
  end

  assert_cmd_hold_R13: assert property (@(posedge clk) disable iff (rst)
    (valid && !done) |=> (valid && $stable(cmd) && $stable(wbyte)));

  assert_issue_free_R13: assert property (@(posedge clk) disable iff (rst)
    issue |-> (!valid || done));

endmodule

// File: rtl/i2cm_flags.sv
module i2cm_flags (
  input  logic clk,
  input  logic rst,
  input  logic soft_rst,
  input  logic en,
  input  logic ien,
  input  logic irq_evt,
  input  logic busy_set,
  input  logic busy_clr,
  input  logic nack_set,
  input  logic nack_clr,
  input  logic arb_set,
  input  logic sw_wr,
  input  logic sw_irq_bit,
  input  logic sw_arb_bit,
  output logic busy,
  output logic arb,
  output logic irq_flag,
  output logic nack
);

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      busy     <= 1'b0;
      arb      <= 1'b0;
      irq_flag <= 1'b0;
      nack     <= 1'b0;
    end else begin
      if (busy_set)      busy <= 1'b1;
      else if (busy_clr) busy <= 1'b0;

      if (nack_set)      nack <= 1'b1;
      else if (nack_clr) nack <= 1'b0;

      if (irq_evt && en && ien)     irq_flag <= 1'b1;
      else if (sw_wr && !sw_irq_bit) irq_flag <= 1'b0;

      if (arb_set)                   arb <= 1'b1;
      else if (sw_wr && !sw_arb_bit) arb <= 1'b0;
    end
  end

  assert_irq_gate_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_flag) |-> $past(en && ien));

  assert_irq_w0c_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_flag) |-> $past(soft_rst || (sw_wr && !sw_irq_bit)));

  assert_arb_w0c_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(arb) |-> $past(soft_rst || (sw_wr && !sw_arb_bit)));

endmodule

// File: rtl/i2cm_host_ctl.sv
module i2cm_host_ctl
  import i2cm_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int BUS_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_req,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BUS_W-1:0]  reg_wdata,
  output logic              reg_ack,
  output logic [BUS_W-1:0]  reg_rdata,
  output logic              irq,
  output logic              txn_valid,
  output logic [1:0]        txn_cmd,
  output logic [7:0]        txn_wbyte,
  input  logic              txn_done,
  input  logic              txn_nack,
  input  logic              txn_lost,
  input  logic [7:0]        txn_rbyte
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);
  localparam logic [ADDR_W-1:0] A_OWN  = ADDR_W'(OFS_OWN);
  localparam logic [ADDR_W-1:0] A_DIV  = ADDR_W'(OFS_DIV);

  // register state
  logic [BYTE_W-1:0] ctrl_q, own_q, div_q, rx_q;
  logic [BUS_W-1:0]  rdata_q;
  logic              open_q, reg_ack_q;
  i2cm_state_e       st_q;
  i2cm_cmd_e         pend_q;

  // flag outputs
  logic busy, arb, irq_flag, nack;

  // port outputs from the command register
  logic      port_valid;
  i2cm_cmd_e port_cmd;
  logic [BYTE_W-1:0] port_wbyte;

  logic [BYTE_W-1:0] wb;
  logic unused_wdata_hi;
  assign wb = reg_wdata[BYTE_W-1:0];
  assign unused_wdata_hi = ^reg_wdata;

  logic en, mst, tx;
  assign en  = ctrl_q[CB_EN];
  assign mst = ctrl_q[CB_MST];
  assign tx  = ctrl_q[CB_TX];

  // access decode
  logic accept, wr_acc, rd_acc, fin;
  logic is_ctrl, is_stat, is_data, is_own, is_div;
  assign accept  = reg_req && !reg_ack_q && (st_q == ST_IDLE);
  assign wr_acc  = accept && reg_we;
  assign rd_acc  = accept && !reg_we;
  assign fin     = (st_q == ST_BUS) && txn_done;
  assign is_ctrl = (reg_addr == A_CTRL);
  assign is_stat = (reg_addr == A_STAT);
  assign is_data = (reg_addr == A_DATA);
  assign is_own  = (reg_addr == A_OWN);
  assign is_div  = (reg_addr == A_DIV);

  logic soft_rst, ctrl_norm, ctrl_stop, data_go, recv_go, chain_stop;
  logic fin_addr_or_tx;
  assign soft_rst   = wr_acc && is_ctrl && en && !wb[CB_EN];
  assign ctrl_norm  = wr_acc && is_ctrl && !soft_rst;
  assign ctrl_stop  = ctrl_norm && open_q && (!wb[CB_MST] || wb[CB_RSTA]);
  assign data_go    = wr_acc && is_data && en && mst;
  assign recv_go    = rd_acc && is_data && mst && open_q && !tx;
  assign fin_addr_or_tx = fin && ((pend_q == CMD_START) || (pend_q == CMD_SEND));
  assign chain_stop = fin && (pend_q == CMD_SEND) && txn_nack;

  // command issue
  logic              issue;
  i2cm_cmd_e         issue_cmd;
  logic [BYTE_W-1:0] issue_byte;

  always_comb begin
    issue      = (soft_rst && open_q) || ctrl_stop || data_go || recv_go || chain_stop;
    issue_cmd  = CMD_STOP;
    issue_byte = '0;
    if (data_go) begin
      issue_cmd  = open_q ? CMD_SEND : CMD_START;
      issue_byte = wb;
    end else if (recv_go) begin
      issue_cmd = CMD_RECV;
    end
  end

  // new control value with repeated start consumed on an open address
  logic [BYTE_W-1:0] ctrl_new;
  always_comb begin
    ctrl_new = wb & MASK_CTRL;
    if (open_q && wb[CB_MST] && wb[CB_RSTA]) ctrl_new[CB_RSTA] = 1'b0;
  end

  // read mux for the plain registers
  logic [BYTE_W-1:0] stat_byte, rd_byte;
  always_comb begin
    stat_byte          = '0;
    stat_byte[SB_BUSY] = busy;
    stat_byte[SB_ARB]  = arb;
    stat_byte[SB_IRQ]  = irq_flag;
    stat_byte[SB_NACK] = nack;
    rd_byte = '0;
    if (is_ctrl)      rd_byte = ctrl_q;
    else if (is_stat) rd_byte = stat_byte;
    else if (is_own)  rd_byte = own_q;
    else if (is_div)  rd_byte = div_q;
  end

  // flag events
  logic irq_evt;
  assign irq_evt = (fin_addr_or_tx && !txn_nack) || (fin && (pend_q == CMD_RECV));

  i2cm_flags u_flags (
    .clk        (clk),
    .rst        (rst),
    .soft_rst   (soft_rst),
    .en         (en),
    .ien        (ctrl_q[CB_IEN]),
    .irq_evt    (irq_evt),
    .busy_set   (ctrl_norm && wb[CB_MST]),
    .busy_clr   (ctrl_norm && !wb[CB_MST]),
    .nack_set   (fin_addr_or_tx && txn_nack),
    .nack_clr   (fin_addr_or_tx && !txn_nack),
    .arb_set    (fin && txn_lost),
    .sw_wr      (wr_acc && is_stat),
    .sw_irq_bit (wb[SB_IRQ]),
    .sw_arb_bit (wb[SB_ARB]),
    .busy       (busy),
    .arb        (arb),
    .irq_flag   (irq_flag),
    .nack       (nack)
  );

  i2cm_txn_port #(.W(BYTE_W)) u_port (
    .clk        (clk),
    .rst        (rst),
    .issue      (issue),
    .issue_cmd  (issue_cmd),
    .issue_byte (issue_byte),
    .done       (txn_done),
    .valid      (port_valid),
    .cmd        (port_cmd),
    .wbyte      (port_wbyte)
  );

  // sequencing and register state
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      own_q     <= '0;
      div_q     <= '0;
      rx_q      <= '0;
      rdata_q   <= '0;
      open_q    <= 1'b0;
      reg_ack_q <= 1'b0;
      st_q      <= ST_IDLE;
      pend_q    <= CMD_STOP;
    end else begin
      reg_ack_q <= 1'b0;
      if (accept) begin
        rdata_q <= '0;
        if (rd_acc) begin
          if (is_data) begin
            if (!recv_go) begin
              if (mst) begin
                rx_q    <= RX_NONE;
                rdata_q <= BUS_W'(RX_NONE);
              end else begin
                rdata_q <= BUS_W'(rx_q);
              end
            end
          end else begin
            rdata_q <= BUS_W'(rd_byte);
          end
        end
        if (soft_rst) begin
          ctrl_q <= '0;
          div_q  <= '0;
          rx_q   <= '0;
          open_q <= 1'b0;
        end else if (ctrl_norm) begin
          ctrl_q <= ctrl_new;
          if (ctrl_stop) open_q <= 1'b0;
        end
        if (wr_acc && is_own) own_q <= wb & MASK_OWN;
        if (wr_acc && is_div) div_q <= wb & MASK_DIV;
        if (issue) begin
          st_q   <= ST_BUS;
          pend_q <= issue_cmd;
        end else begin
          reg_ack_q <= 1'b1;
        end
      end else if (fin) begin
        case (pend_q)
          CMD_START: if (!txn_nack) open_q <= 1'b1;
          CMD_SEND:  if (txn_nack) open_q <= 1'b0;
          CMD_RECV: begin
            rx_q    <= txn_rbyte;
            rdata_q <= BUS_W'(txn_rbyte);
          end
          default: ;
        endcase
        if (chain_stop) begin
          pend_q <= CMD_STOP;
        end else begin
          st_q      <= ST_IDLE;
          reg_ack_q <= 1'b1;
        end
      end
    end
  end

  assign reg_ack   = reg_ack_q;
  assign reg_rdata = rdata_q;
  assign irq       = irq_flag;
  assign txn_valid = port_valid;
  assign txn_cmd   = port_cmd;
  assign txn_wbyte = port_wbyte;

  assert_ack_pulse_R13: assert property (@(posedge clk) disable iff (rst)
    reg_ack |=> !reg_ack);

  assert_ack_after_done_R13: assert property (@(posedge clk) disable iff (rst)
    (reg_ack && $past(st_q == ST_BUS)) |-> $past(txn_done));

  assert_busy_src_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(wr_acc && is_ctrl && reg_wdata[CB_MST]));

  assert_start_enabled_R8: assert property (@(posedge clk) disable iff (rst)
    (txn_valid && (txn_cmd == CMD_START)) |-> (ctrl_q[CB_EN] && ctrl_q[CB_MST]));

endmodule

// File: tb/test_i2cm_host_ctl.sv
module test_i2cm_host_ctl;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 3;
  localparam int BUS_W  = 16;
  localparam int WDOG   = 20000;

  logic clk, rst;
  logic reg_req, reg_we, reg_ack, irq, txn_valid, txn_done, txn_nack, txn_lost;
  logic [ADDR_W-1:0] reg_addr;
  logic [BUS_W-1:0]  reg_wdata, reg_rdata;
  logic [1:0] txn_cmd;
  logic [7:0] txn_wbyte, txn_rbyte;

  i2cm_host_ctl #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) i_i2cm_host_ctl (
    .clk(clk), .rst(rst), .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_ack(reg_ack), .reg_rdata(reg_rdata), .irq(irq),
    .txn_valid(txn_valid), .txn_cmd(txn_cmd), .txn_wbyte(txn_wbyte),
    .txn_done(txn_done), .txn_nack(txn_nack), .txn_lost(txn_lost), .txn_rbyte(txn_rbyte)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit in_acc = 1'b1;

  // reference model state
  logic [7:0] m_ctrl, m_own, m_div, m_rx;
  bit m_busy, m_arb, m_irq, m_nack, m_open;
  logic [9:0] exp_q[$];
  logic [9:0] got_q[$];
  bit resp_nack, resp_lost;
  logic [7:0] resp_byte;

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    n_bad++;
    $display("FAIL R13 watchdog actual=hung expected=done");
    summary();
  end

  // bus engine responder
  initial begin
    txn_done = 1'b0; txn_nack = 1'b0; txn_lost = 1'b0; txn_rbyte = '0;
    forever begin
      @(negedge clk);
      if (txn_valid === 1'b1) begin
        logic [1:0] c0;
        logic [7:0] b0;
        c0 = txn_cmd; b0 = txn_wbyte;
        repeat (2) begin
          @(negedge clk);
          check(reg_ack == 1'b0, "R13 ack before done", reg_ack, 0);
          check(txn_valid && txn_cmd == c0 && txn_wbyte == b0, "R13 hold", txn_cmd, c0);
        end
        got_q.push_back({c0, (c0 <= 2'd1) ? b0 : 8'h00});
        txn_nack = resp_nack; txn_lost = resp_lost; txn_rbyte = resp_byte;
        txn_done = 1'b1;
        @(negedge clk);
        txn_done = 1'b0;
      end
    end
  end

  // every-clock comparison outside accesses
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && !in_acc) begin
        check(irq === m_irq, "R6 R7 irq level", irq, m_irq);
        check(txn_valid === 1'b0, "R13 idle port", txn_valid, 0);
      end
    end
  end

  function automatic void irq_evt();
    if (m_ctrl[7] && m_ctrl[6]) m_irq = 1'b1;
  endfunction

  function automatic logic [7:0] m_stat();
    return {2'b00, m_busy, m_arb, 2'b00, m_irq, m_nack};
  endfunction

  task automatic acc(input bit we, input int addr, input int wd, output logic [15:0] rd);
    in_acc = 1'b1;
    @(negedge clk);
    reg_req = 1'b1; reg_we = we; reg_addr = addr[ADDR_W-1:0]; reg_wdata = wd[BUS_W-1:0];
    do @(negedge clk); while (reg_ack !== 1'b1);
    rd = reg_rdata;
    reg_req = 1'b0;
    in_acc = 1'b0;
  endtask

  task automatic cmp_cmds(input string tag);
    check(got_q.size() == exp_q.size(), tag, got_q.size(), exp_q.size());
    foreach (exp_q[i]) begin
      if (i < got_q.size()) check(got_q[i] == exp_q[i], tag, got_q[i], exp_q[i]);
    end
    got_q.delete();
    exp_q.delete();
  endtask

  task automatic wr(input int addr, input int val, input string tag);
    logic [7:0] v;
    logic [15:0] rd;
    bit was;
    v = val[7:0];
    case (addr)
      0: begin
        if (m_ctrl[7] && !v[7]) begin
          if (m_open) exp_q.push_back({2'd3, 8'h00});
          m_ctrl = 0; m_div = 0; m_rx = 0; m_open = 0;
          m_busy = 0; m_arb = 0; m_irq = 0; m_nack = 0;
        end else begin
          was = m_open;
          m_ctrl = v & 8'hFC;
          m_busy = v[5];
          if (was && (!v[5] || v[2])) begin
            exp_q.push_back({2'd3, 8'h00});
            m_open = 0;
          end
          if (was && v[5] && v[2]) m_ctrl[2] = 1'b0;
        end
      end
      1: begin
        if (m_irq && !v[1]) m_irq = 0;
        if (m_arb && !v[4]) m_arb = 0;
      end
      2: if (m_ctrl[7] && m_ctrl[5]) begin
        if (resp_lost) m_arb = 1;
        if (!m_open) begin
          exp_q.push_back({2'd0, v});
          if (resp_nack) m_nack = 1;
          else begin m_open = 1; m_nack = 0; irq_evt(); end
        end else begin
          exp_q.push_back({2'd1, v});
          if (resp_nack) begin
            m_nack = 1; m_open = 0;
            exp_q.push_back({2'd3, 8'h00});
          end else begin
            m_nack = 0; irq_evt();
          end
        end
      end
      3: m_own = v & 8'hFE;
      4: m_div = v & 8'h3F;
      default: ;
    endcase
    acc(1'b1, addr, val, rd);
    cmp_cmds(tag);
  endtask

  task automatic rd_chk(input int addr, input string tag);
    logic [7:0] e;
    logic [15:0] rd;
    case (addr)
      0: e = m_ctrl;
      1: e = m_stat();
      2: begin
        if (m_ctrl[5]) begin
          if (m_open && !m_ctrl[4]) begin
            exp_q.push_back({2'd2, 8'h00});
            if (resp_lost) m_arb = 1;
            m_rx = resp_byte;
            irq_evt();
          end else begin
            m_rx = 8'hFF;
          end
        end
        e = m_rx;
      end
      3: e = m_own;
      4: e = m_div;
      default: e = 8'h00;
    endcase
    acc(1'b0, addr, 0, rd);
    check(rd == {8'h00, e}, tag, rd, e);
    cmp_cmds(tag);
  endtask

  initial begin
    rst = 1'b1; reg_req = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    m_ctrl = 0; m_own = 0; m_div = 0; m_rx = 0;
    m_busy = 0; m_arb = 0; m_irq = 0; m_nack = 0; m_open = 0;
    resp_nack = 0; resp_lost = 0; resp_byte = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(irq == 1'b0 && txn_valid == 1'b0, "R1 outputs", {irq, txn_valid}, 0);
    for (int a = 0; a < 8; a++) rd_chk(a, "R1 reset value");
    in_acc = 1'b0;

    // masks, low byte only, undefined offsets
    wr(3, 8'hFF, "R2");   rd_chk(3, "R2 own mask");
    wr(4, 8'hFF, "R2");   rd_chk(4, "R2 div mask");
    wr(3, 16'h1AB, "R2"); rd_chk(3, "R2 low byte");
    wr(7, 8'hFF, "R2");   rd_chk(7, "R2 undefined");
    wr(0, 8'hFF, "R2");   rd_chk(0, "R2 ctrl mask");
    wr(0, 8'h00, "R3");

    // disabled: data write ignored
    wr(2, 8'hA4, "R8 disabled");
    rd_chk(1, "R8 disabled status");

    // enable master with interrupts
    wr(0, 8'hE0, "R4"); rd_chk(1, "R4 busy set");
    wr(2, 8'hA4, "R8 start ack"); rd_chk(1, "R8 status");
    wr(1, 8'hFF, "R6 write one"); rd_chk(1, "R6 flag kept");
    wr(1, 8'h00, "R6 write zero"); rd_chk(1, "R6 flag cleared");
    wr(2, 8'h5A, "R9 send ack"); wr(1, 8'h00, "R6");
    resp_byte = 8'h3C;
    rd_chk(2, "R10 receive"); wr(1, 8'h00, "R6");
    resp_nack = 1;
    wr(2, 8'h77, "R9 send nack"); rd_chk(1, "R9 nack status");
    wr(2, 8'hA5, "R8 start nack"); rd_chk(1, "R8 nack status");
    resp_nack = 0;
    wr(2, 8'hA5, "R8 start reopens");
    wr(1, 8'h00, "R6");

    // repeated start on an open address
    wr(0, 8'hE4, "R5 restart stop"); rd_chk(0, "R5 bit cleared");
    rd_chk(2, "R10 no address");
    wr(2, 8'hA4, "R5 new address phase");

    // transmit direction blocks receive
    wr(0, 8'hF0, "R10"); rd_chk(2, "R10 tx set");

    // interrupt enable clear
    wr(0, 8'hA0, "R7"); wr(1, 8'h00, "R7");
    wr(2, 8'h11, "R7 no irq"); rd_chk(1, "R7 status");

    // arbitration lost
    wr(0, 8'hE0, "R12");
    resp_lost = 1;
    wr(2, 8'h22, "R12 lost"); resp_lost = 0;
    rd_chk(1, "R12 flag");
    wr(1, 8'h10, "R6 arb kept"); rd_chk(1, "R6 arb kept");
    wr(1, 8'h00, "R6 arb clear"); rd_chk(1, "R6 arb cleared");

    // leave master mode with an open address
    wr(0, 8'h80, "R4 stop on slave"); rd_chk(1, "R4 busy cleared");

    // slave mode data access
    wr(2, 8'h99, "R11 no command"); rd_chk(2, "R11 held value");

    // soft reset keeps own address
    wr(4, 8'h15, "R3"); wr(3, 8'h42, "R3");
    wr(0, 8'hE0, "R3"); wr(2, 8'hA4, "R3");
    wr(0, 8'h00, "R3 soft reset stop");
    for (int a = 0; a < 5; a++) rd_chk(a, "R3 after soft reset");
    check(irq == 1'b0, "R3 irq", irq, 0);

    // master set while disabled is a normal write
    wr(0, 8'h20, "R4 disabled master"); rd_chk(1, "R4 busy");
    wr(2, 8'h33, "R8 ignored disabled"); rd_chk(2, "R10 read 0xFF");

    repeat (4) @(negedge clk);
    summary();
  end

endmodule